// File: doc/BRIEF.md
# Auxiliary System Control Register Bank

This block is a memory-mapped slave that holds the small housekeeping registers of a workstation I/O companion device. It contains seven registers:

- a configuration byte;
- a diagnostic byte;
- a modem-control byte;
- two auxiliary bytes;
- a 16-bit indicator-lamp register;
- a 32-bit system-control register.

Each register has its own select line on a simple register bus. The bus carries a transfer size of byte, halfword or word, a small offset and a 32-bit data path. Reads are combinational from the current state. Writes take effect at the clock edge.

Besides storage, the block turns some register writes into side effects:

- It keeps a power-fail status bit that follows an external power-fail input, and raises a level interrupt from that bit when the interrupt is enabled.
- It emits a one-clock terminal-count strobe for a floppy controller.
- It raises a power-off request and a system-reset request. Both stay asserted until the block is reset.

Two resets exist. `por_n` clears everything. `rst_n` is the block reset: it clears the working control registers and the requests, but keeps the diagnostic byte, the lamp register and the system-control register, so that the reset-status flag survives the reset it reports.

Top module: `aux_ctl_bank`

## Requirements
- R1: `irq_o` is high exactly when aux2 bit 5 (power-fail status) and configuration bit 3 (power-interrupt enable) are both set in the stored registers.
- R2: In the clock cycle after `pwr_fail_i` differs from its value in the previous cycle, aux2 bit 5 equals `pwr_fail_i` AND the configuration bit 3 that was stored before that edge. Such a change takes precedence over an aux2 write in the same cycle. Without a change, only an aux2 write can alter bit 5.
- R3: A byte write to aux1 (select line 3) with data bit 1 set gives a `tc_pulse_o` pulse of exactly one clock in the following cycle. Aux1 then stores the data with bit 1 forced to zero.
- R4: A byte write to aux2 (select line 4) keeps data bits 0 and 1 and merges in the current bit 5. If data bit 1 is set, only bit 0 remains, so bit 5 is cleared. Stored bit 1 is always zero.
- R5: An aux2 write that leaves bit 0 set raises `pwroff_req_o` from the next cycle, and it stays high until reset.
- R6: A word write to system control (select line 6) at offset 0 with data bit 0 set loads the register with 0x02 and raises `sysrst_req_o`, which stays high until reset. A write with bit 0 clear, or at a nonzero offset, changes nothing.
- R7: A halfword write to the lamp register (select line 5) at offset 0 stores data bits 15:0. Writes at other offsets are ignored. Lamp and system-control reads return zero at nonzero offsets.
- R8: Block reset (`rst_n` low) clears configuration, aux1, aux2, modem control, both requests and both strobes. It keeps the diagnostic, lamp and system-control contents. `por_n` low clears everything.
- R9: Size codes are 0 for byte, 1 for halfword and 2 for word; code 3 matches no register. Select lines 0 to 4 need byte, line 5 needs halfword and line 6 needs word. A mismatched access writes nothing, reads zero, and raises `size_err_o` for one clock in the next cycle.
- R10: Byte registers (configuration on line 0, diagnostic on line 1, modem on line 2) read back the written byte in bits 7:0, with zero above. When several select lines are high, the lowest-numbered one wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous, clears all state |
| rst_n | input | 1 | Block reset, active low, synchronous |
| bus_sel | input | 7 | One select line per register (0 cfg, 1 diag, 2 modem, 3 aux1, 4 aux2, 5 lamp, 6 sysctl) |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_size | input | 2 | Transfer size: 0 byte, 1 halfword, 2 word |
| bus_off | input | 2 | Byte offset within the selected register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| pwr_fail_i | input | 1 | External power-fail indication |
| irq_o | output | 1 | Power-fail interrupt level |
| tc_pulse_o | output | 1 | One-clock terminal-count strobe |
| pwroff_req_o | output | 1 | Sticky power-off request |
| sysrst_req_o | output | 1 | Sticky system-reset request |
| size_err_o | output | 1 | One-clock access-size error flag |

## Verification
The bench drives a power-fail edge in the same cycle as an aux2 clear write. A design that ordered those two events the other way would lose the status bit and leave the interrupt low. It also writes aux1 with every bit set: a design that stored the strobe bit would read back 0xFF, and one that stretched the strobe would show it for two clocks. It resets the block after loading the diagnostic, lamp and system-control registers, which exposes any register placed in the wrong reset domain. Accesses with the wrong size, and lamp and system-control accesses at nonzero offsets, catch decoders that ignore size or offset.

// File: rtl/aux_ctl_pkg.sv
package aux_ctl_pkg;

  localparam int NREG = 7;

  typedef enum logic [2:0] {
    RI_CFG  = 3'd0,
    RI_DIAG = 3'd1,
    RI_MDM  = 3'd2,
    RI_AUX1 = 3'd3,
    RI_AUX2 = 3'd4,
    RI_LAMP = 3'd5,
    RI_SYS  = 3'd6
  } reg_idx_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSV  = 2'd3
  } acc_size_e;

  localparam int CFG_PIE_BIT  = 3;
  localparam int AUX1_TC_BIT  = 1;
  localparam int AUX2_OFF_BIT = 0;
  localparam int AUX2_CLR_BIT = 1;
  localparam int AUX2_PF_BIT  = 5;
  localparam int SYS_GO_BIT   = 0;
  localparam logic [7:0] SYS_RST_STAT = 8'h02;

  // Transfer size each register accepts.
  function automatic acc_size_e need_size(reg_idx_e idx);
    case (idx)
      RI_LAMP: return SZ_HALF;
      RI_SYS:  return SZ_WORD;
      default: return SZ_BYTE;
    endcase
  endfunction

  // Aux1 stores everything except the strobe bit.
  function automatic logic [7:0] aux1_keep(logic [7:0] d);
    logic [7:0] r;
    r = d;
    r[AUX1_TC_BIT] = 1'b0;
    return r;
  endfunction

  // Aux2 write merge: keep bits 0/1 of data, carry status bit, clear drops it.
  function automatic logic [7:0] aux2_merge(logic [7:0] cur, logic [7:0] d);
    logic [7:0] r;
    r = 8'h00;
    r[AUX2_OFF_BIT] = d[AUX2_OFF_BIT];
    r[AUX2_PF_BIT]  = cur[AUX2_PF_BIT] & ~d[AUX2_CLR_BIT];
    return r;
  endfunction

endpackage

// File: rtl/aux_ctl_dec.sv
module aux_ctl_dec
  import aux_ctl_pkg::*;
(
  input  logic [NREG-1:0] sel,
  input  logic            wr,
  input  logic            rd,
  input  logic [1:0]      size,
  output reg_idx_e        idx,
  output logic            hit,
  output logic            size_bad,
  output logic            wr_ok,
  output logic            rd_ok
);

  // Lowest-numbered select wins.
  always_comb begin
    hit = 1'b0;
    idx = RI_CFG;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (sel[i]) begin
        hit = 1'b1;
        idx = reg_idx_e'(3'(i));
      end
    end
  end

  assign size_bad = hit && (wr || rd) && (acc_size_e'(size) != need_size(idx));
  assign wr_ok    = hit && wr && !size_bad;
  assign rd_ok    = hit && rd && !size_bad;

endmodule

// File: rtl/aux_ctl_pwr.sv
module aux_ctl_pwr
  import aux_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_blk,
  input  logic       cfg_wr,
  input  logic       aux2_wr,
  input  logic [7:0] wbyte,
  input  logic       pf_in,
  output logic [7:0] cfg_q,
  output logic [7:0] aux2_q,
  output logic       pf_evt,
  output logic       irq_o,
  output logic       pwroff_req_o
);

  logic       pf_q;
  logic [7:0] aux2_d;

  assign pf_evt = pf_in ^ pf_q;

  // Input change is applied after any write, so it wins for the status bit.
  always_comb begin
    aux2_d = aux2_q;
    if (aux2_wr) aux2_d = aux2_merge(aux2_q, wbyte);
    if (pf_evt)  aux2_d[AUX2_PF_BIT] = pf_in & cfg_q[CFG_PIE_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst_blk) begin
      cfg_q        <= 8'h00;
      aux2_q       <= 8'h00;
      pf_q         <= 1'b0;
      pwroff_req_o <= 1'b0;
    end else begin
      pf_q   <= pf_in;
      aux2_q <= aux2_d;
      if (cfg_wr) cfg_q <= wbyte;
      if (aux2_wr && aux2_d[AUX2_OFF_BIT]) pwroff_req_o <= 1'b1;
    end
  end

  assign irq_o = aux2_q[AUX2_PF_BIT] & cfg_q[CFG_PIE_BIT];

endmodule

// File: rtl/aux_ctl_misc.sv
module aux_ctl_misc
  import aux_ctl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LAMP_W = 16,
  parameter int OFF_W  = 2
) (
  input  logic              clk,
  input  logic              rst_blk,
  input  logic              rst_por,
  input  logic [NREG-1:0]   wr_vec,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] wdata,
  output logic [7:0]        diag_q,
  output logic [7:0]        mdm_q,
  output logic [7:0]        aux1_q,
  output logic [LAMP_W-1:0] lamp_q,
  output logic [7:0]        sys_q,
  output logic              tc_o,
  output logic              sysrst_o
);

  logic at_base;
  logic sys_go;

  assign at_base = (off == '0);
  assign sys_go  = wr_vec[RI_SYS] && at_base && wdata[SYS_GO_BIT];

  // Block-reset domain.
  always_ff @(posedge clk) begin
    if (rst_blk) begin
      mdm_q    <= 8'h00;
      aux1_q   <= 8'h00;
      tc_o     <= 1'b0;
      sysrst_o <= 1'b0;
    end else begin
      tc_o <= wr_vec[RI_AUX1] && wdata[AUX1_TC_BIT];
      if (wr_vec[RI_MDM])  mdm_q  <= wdata[7:0];
      if (wr_vec[RI_AUX1]) aux1_q <= aux1_keep(wdata[7:0]);
      if (sys_go)          sysrst_o <= 1'b1;
    end
  end

  // Power-on-only domain: survives block reset.
  always_ff @(posedge clk) begin
    if (rst_por) begin
      diag_q <= 8'h00;
      lamp_q <= '0;
      sys_q  <= 8'h00;
    end else begin
      if (wr_vec[RI_DIAG])            diag_q <= wdata[7:0];
      if (wr_vec[RI_LAMP] && at_base) lamp_q <= wdata[LAMP_W-1:0];
      if (sys_go)                     sys_q  <= SYS_RST_STAT;
    end
  end

endmodule

// File: rtl/aux_ctl_bank.sv
module aux_ctl_bank
  import aux_ctl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LAMP_W = 16,
  parameter int OFF_W  = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic [NREG-1:0]   bus_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_size,
  input  logic [OFF_W-1:0]  bus_off,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              pwr_fail_i,
  output logic              irq_o,
  output logic              tc_pulse_o,
  output logic              pwroff_req_o,
  output logic              sysrst_req_o,
  output logic              size_err_o
);

  logic             rst_blk, rst_por;
  reg_idx_e         idx;
  logic             hit, size_bad, wr_ok, rd_ok;
  logic [NREG-1:0]  wr_vec;
  logic [7:0]       cfg_q, aux2_q, diag_q, mdm_q, aux1_q, sys_q;
  logic [LAMP_W-1:0] lamp_q;
  logic             pf_evt;

  assign rst_por = !por_n;
  assign rst_blk = !por_n || !rst_n;

  aux_ctl_dec u_dec (
    .sel(bus_sel), .wr(bus_wr), .rd(bus_rd), .size(bus_size),
    .idx(idx), .hit(hit), .size_bad(size_bad), .wr_ok(wr_ok), .rd_ok(rd_ok)
  );

  for (genvar g = 0; g < NREG; g++) begin : g_wr
    assign wr_vec[g] = wr_ok && (idx == reg_idx_e'(3'(g)));
  end

  aux_ctl_pwr u_pwr (
    .clk(clk), .rst_blk(rst_blk),
    .cfg_wr(wr_vec[RI_CFG]), .aux2_wr(wr_vec[RI_AUX2]),
    .wbyte(bus_wdata[7:0]), .pf_in(pwr_fail_i),
    .cfg_q(cfg_q), .aux2_q(aux2_q), .pf_evt(pf_evt),
    .irq_o(irq_o), .pwroff_req_o(pwroff_req_o)
  );

  aux_ctl_misc #(.DATA_W(DATA_W), .LAMP_W(LAMP_W), .OFF_W(OFF_W)) u_misc (
    .clk(clk), .rst_blk(rst_blk), .rst_por(rst_por),
    .wr_vec(wr_vec), .off(bus_off), .wdata(bus_wdata),
    .diag_q(diag_q), .mdm_q(mdm_q), .aux1_q(aux1_q), .lamp_q(lamp_q),
    .sys_q(sys_q), .tc_o(tc_pulse_o), .sysrst_o(sysrst_req_o)
  );

  always_comb begin
    bus_rdata = '0;
    if (rd_ok) begin
      case (idx)
        RI_CFG:  bus_rdata = DATA_W'(cfg_q);
        RI_DIAG: bus_rdata = DATA_W'(diag_q);
        RI_MDM:  bus_rdata = DATA_W'(mdm_q);
        RI_AUX1: bus_rdata = DATA_W'(aux1_q);
        RI_AUX2: bus_rdata = DATA_W'(aux2_q);
        RI_LAMP: if (bus_off == '0) bus_rdata = DATA_W'(lamp_q);
        RI_SYS:  if (bus_off == '0) bus_rdata = DATA_W'(sys_q);
        default: bus_rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst_blk) size_err_o <= 1'b0;
    else         size_err_o <= size_bad;
  end

endmodule

// File: rtl/aux_ctl_chk.sv
module aux_ctl_chk
  import aux_ctl_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              por_n,
  input logic              rst_n,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              pwr_fail_i,
  input logic              irq_o,
  input logic              tc_pulse_o,
  input logic              pwroff_req_o,
  input logic              sysrst_req_o,
  input logic              size_err_o,
  input logic [7:0]        cfg_q,
  input logic [7:0]        aux2_q,
  input logic [7:0]        aux1_q,
  input logic [NREG-1:0]   wr_vec,
  input logic              pf_evt,
  input logic              size_bad
);

  // R2: rising input with enable set records the status bit
  a_r2_pf_sets: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (pf_evt && pwr_fail_i && cfg_q[CFG_PIE_BIT]) |=> aux2_q[AUX2_PF_BIT]);

  // R2: falling input clears the status bit
  a_r2_pf_clears: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (pf_evt && !pwr_fail_i) |=> !aux2_q[AUX2_PF_BIT]);

  // R1: interrupt follows a recorded power fail when enable is untouched
  a_r1_irq_on_fail: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (pf_evt && pwr_fail_i && cfg_q[CFG_PIE_BIT] && !wr_vec[RI_CFG]) |=> irq_o);

  // R3: strobe only after an aux1 write carrying bit 1
  a_r3_tc_cause: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    tc_pulse_o |-> $past(wr_vec[RI_AUX1] && bus_wdata[AUX1_TC_BIT]));

  // R3: strobe bit never stored
  a_r3_aux1_no_tc: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    !aux1_q[AUX1_TC_BIT]);

  // R4: clear bit never stored
  a_r4_aux2_no_clr: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    !aux2_q[AUX2_CLR_BIT]);

  // R5: power-off request is sticky
  a_r5_pwroff_hold: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    pwroff_req_o |=> pwroff_req_o);

  // R6: reset request is sticky
  a_r6_sysrst_hold: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    sysrst_req_o |=> sysrst_req_o);

  // R9: error flag only after a mismatched access
  a_r9_err_cause: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    size_err_o |-> $past(size_bad));

endmodule

bind aux_ctl_bank aux_ctl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .por_n(por_n), .rst_n(rst_n), .bus_wdata(bus_wdata),
  .pwr_fail_i(pwr_fail_i), .irq_o(irq_o), .tc_pulse_o(tc_pulse_o),
  .pwroff_req_o(pwroff_req_o), .sysrst_req_o(sysrst_req_o),
  .size_err_o(size_err_o), .cfg_q(cfg_q), .aux2_q(aux2_q), .aux1_q(aux1_q),
  .wr_vec(wr_vec), .pf_evt(pf_evt), .size_bad(size_bad)
);

// File: tb/tb_aux_ctl_bank.sv
`timescale 1ns/1ps
module tb_aux_ctl_bank;

  logic        clk = 1'b0;
  logic        por_n, rst_n;
  logic [6:0]  bus_sel;
  logic        bus_wr, bus_rd;
  logic [1:0]  bus_size, bus_off;
  logic [31:0] bus_wdata, bus_rdata;
  logic        pwr_fail_i;
  logic        irq_o, tc_pulse_o, pwroff_req_o, sysrst_req_o, size_err_o;

  always #2.5 clk = ~clk;

  aux_ctl_bank dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_size(bus_size), .bus_off(bus_off),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwr_fail_i(pwr_fail_i),
    .irq_o(irq_o), .tc_pulse_o(tc_pulse_o), .pwroff_req_o(pwroff_req_o),
    .sysrst_req_o(sysrst_req_o), .size_err_o(size_err_o)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Reference model
  logic [7:0]  m_cfg, m_diag, m_mdm, m_aux1, m_aux2, m_sys;
  logic [15:0] m_lamp;
  logic        m_pf_prev, m_tc, m_err, m_off, m_rst;
  logic        pf_now;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int need(int i);
    if (i == 5) return 1;
    if (i == 6) return 2;
    return 0;
  endfunction

  function automatic logic [31:0] m_read(int i, int sz, int off);
    if (sz != need(i)) return 32'h0;
    case (i)
      0: return {24'h0, m_cfg};
      1: return {24'h0, m_diag};
      2: return {24'h0, m_mdm};
      3: return {24'h0, m_aux1};
      4: return {24'h0, m_aux2};
      5: return (off == 0) ? {16'h0, m_lamp} : 32'h0;
      default: return (off == 0) ? {24'h0, m_sys} : 32'h0;
    endcase
  endfunction

  function automatic logic [7:0] m_aux2_wr(logic [7:0] cur, logic [7:0] d);
    logic [7:0] t;
    t = {2'b00, cur[5], 3'b000, d[1:0]};
    if (d[1]) t = {7'h00, d[0]};
    return t;
  endfunction

  task automatic check_outs();
    chk("R1 irq_o", {31'h0, irq_o}, {31'h0, m_aux2[5] & m_cfg[3]});
    chk("R3 tc_pulse_o", {31'h0, tc_pulse_o}, {31'h0, m_tc});
    chk("R9 size_err_o", {31'h0, size_err_o}, {31'h0, m_err});
    chk("R5 pwroff_req_o", {31'h0, pwroff_req_o}, {31'h0, m_off});
    chk("R6 sysrst_req_o", {31'h0, sysrst_req_o}, {31'h0, m_rst});
  endtask

  // One bus cycle. i < 0 means no select.
  task automatic op(string req, int i, bit w, bit r, int sz, int off,
                    logic [31:0] d, logic pf);
    logic       err_n, tc_n;
    logic [7:0] old_cfg, a2;
    @(negedge clk);
    check_outs();
    bus_sel   = (i >= 0) ? 7'(1 << i) : 7'h0;
    bus_wr    = w;
    bus_rd    = r;
    bus_size  = 2'(sz);
    bus_off   = 2'(off);
    bus_wdata = d;
    pwr_fail_i = pf;
    pf_now    = pf;
    #1;
    if (r && i >= 0) chk(req, bus_rdata, m_read(i, sz, off));
    err_n   = (w || r) && (i >= 0) && (sz != need(i));
    tc_n    = 1'b0;
    old_cfg = m_cfg;
    a2      = m_aux2;
    if (w && i >= 0 && !err_n) begin
      case (i)
        0: m_cfg  = d[7:0];
        1: m_diag = d[7:0];
        2: m_mdm  = d[7:0];
        3: begin m_aux1 = d[7:0] & 8'hFD; tc_n = d[1]; end
        4: begin a2 = m_aux2_wr(m_aux2, d[7:0]); if (a2[0]) m_off = 1'b1; end
        5: if (off == 0) m_lamp = d[15:0];
        default: if (off == 0 && d[0]) begin m_sys = 8'h02; m_rst = 1'b1; end
      endcase
    end
    if (pf !== m_pf_prev) a2[5] = pf & old_cfg[3];
    m_pf_prev = pf;
    m_aux2 = a2;
    m_tc   = tc_n;
    m_err  = err_n;
  endtask

  task automatic idle();
    op("idle", -1, 0, 0, 0, 0, 32'h0, pf_now);
  endtask

  task automatic rd(string req, int i, int sz, int off);
    op(req, i, 0, 1, sz, off, 32'h0, pf_now);
  endtask

  task automatic wr(string req, int i, int sz, int off, logic [31:0] d);
    op(req, i, 1, 0, sz, off, d, pf_now);
  endtask

  task automatic clear_blk_model();
    m_cfg = 0; m_aux1 = 0; m_aux2 = 0; m_mdm = 0;
    m_tc = 0; m_err = 0; m_off = 0; m_rst = 0; m_pf_prev = 0;
  endtask

  task automatic blk_reset();
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; bus_rd = 0; rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    clear_blk_model();
    @(posedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'h5EED_1234));
    por_n = 1'b0; rst_n = 1'b0;
    bus_sel = 0; bus_wr = 0; bus_rd = 0; bus_size = 0; bus_off = 0;
    bus_wdata = 0; pwr_fail_i = 0; pf_now = 0;
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    clear_blk_model();
    m_diag = 0; m_lamp = 0; m_sys = 0;
    @(posedge clk);

    // R8: power-on state of every register
    for (int i = 0; i < 7; i++) rd("R8 reset read", i, need(i), 0);

    // R10: byte registers
    wr("R10 cfg", 0, 0, 0, 32'hFFFF_FF08);
    wr("R10 diag", 1, 0, 0, 32'h0000_00A5);
    wr("R10 mdm", 2, 0, 0, 32'h0000_003C);
    rd("R10 cfg read", 0, 0, 0);
    rd("R10 diag read", 1, 0, 0);
    rd("R10 mdm read", 2, 0, 0);
    // R10: lowest select wins on a read of cfg and diag together
    @(negedge clk);
    check_outs();
    bus_sel = 7'b0000011; bus_rd = 1; bus_wr = 0; bus_size = 0; bus_off = 0;
    #1 chk("R10 select priority", bus_rdata, {24'h0, m_cfg});
    m_err = 0; m_tc = 0;
    @(posedge clk);

    // R2/R1: power fail with enable set
    pf_now = 1; idle();
    rd("R2 aux2 status set", 4, 0, 0);
    // R4: clear via aux2 write
    wr("R4 aux2 clear", 4, 0, 0, 32'h02);
    rd("R4 aux2 after clear", 4, 0, 0);
    idle();
    rd("R2 no change keeps cleared", 4, 0, 0);
    pf_now = 0; idle();
    pf_now = 1; idle();
    // R4: write with bits 0/1 zero keeps status
    wr("R4 aux2 merge", 4, 0, 0, 32'hFC);
    rd("R4 aux2 merged", 4, 0, 0);
    // R2: input change wins over same-cycle clear
    pf_now = 0; idle();
    op("R2 change vs clear", 4, 1, 0, 0, 0, 32'h02, 1'b1);
    pf_now = 1;
    rd("R2 status after race", 4, 0, 0);
    // R2: enable clear -> change clears
    wr("R1 disable", 0, 0, 0, 32'h00);
    idle();
    pf_now = 0; idle();
    pf_now = 1; idle();
    rd("R2 disabled fail", 4, 0, 0);
    pf_now = 0; idle();

    // R3: terminal count
    wr("R3 aux1 strobe", 3, 0, 0, 32'hFF);
    idle();
    rd("R3 aux1 read", 3, 0, 0);
    wr("R3 aux1 no strobe", 3, 0, 0, 32'h41);
    rd("R3 aux1 read2", 3, 0, 0);

    // R9: size mismatch
    wr("R9 cfg half write", 0, 1, 0, 32'h77);
    rd("R9 cfg after bad write", 0, 0, 0);
    rd("R9 lamp byte read", 5, 0, 0);
    rd("R9 sys reserved size", 6, 3, 0);
    idle();

    // R7: lamp register
    wr("R7 lamp write", 5, 1, 0, 32'h1234_BEEF);
    wr("R7 lamp offset write", 5, 1, 2, 32'h0000_1111);
    rd("R7 lamp read", 5, 1, 0);
    rd("R7 lamp offset read", 5, 1, 1);

    // R6: system control
    wr("R6 sys bit0 clear", 6, 2, 0, 32'hFFFF_FFFE);
    rd("R6 sys unchanged", 6, 2, 0);
    wr("R6 sys offset", 6, 2, 1, 32'h1);
    rd("R6 sys unchanged2", 6, 2, 0);
    wr("R6 sys go", 6, 2, 0, 32'h1);
    rd("R6 sys status", 6, 2, 0);
    rd("R7 sys offset read", 6, 2, 3);

    // R5: power off
    wr("R5 aux2 off", 4, 0, 0, 32'h01);
    rd("R5 aux2 read", 4, 0, 0);
    idle(); idle();

    // R8: block reset keeps diag, lamp, sys
    blk_reset();
    for (int i = 0; i < 7; i++) rd("R8 after block reset", i, need(i), 0);

    // Random mix against the model
    for (int n = 0; n < 600; n++) begin
      int i, sz, off;
      bit w, r;
      logic [31:0] d;
      logic pf;
      i   = int'($urandom_range(7)) - 1;
      w   = $urandom_range(1) == 1;
      r   = !w && ($urandom_range(3) != 0);
      sz  = ($urandom_range(3) == 0) ? int'($urandom_range(3)) : ((i >= 0) ? need(i) : 0);
      off = ($urandom_range(3) == 0) ? int'($urandom_range(3)) : 0;
      d   = $urandom;
      if (i == 4 && $urandom_range(7) != 0) d[0] = 1'b0;
      pf  = ($urandom_range(5) == 0) ? ~pf_now : pf_now;
      pf_now = pf;
      op("R1 R2 R4 R9 random", i, w, r, sz, off, d, pf);
      if (n == 300) blk_reset();
    end
    idle();
    @(negedge clk);
    check_outs();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule